// File: doc/BRIEF.md
# Double-Buffered Serial Character Transmitter

This block turns characters into asynchronous serial frames on a single output line. A one-entry holding register sits in front of the shift register, so software can queue the next character while the current one is still leaving the pin. Characters of 5 to 9 bits are written through a register-style write port. The ninth bit comes from a separate staging bit that is written before the low byte.

Each frame has a low start bit, the data bits least significant first, an optional even or odd parity bit, and one or two high stop bits. Every bit ends on a clock edge at which the external baud tick input is high. The block reports whether the holding register can take a character, and whether everything queued has gone out. When the enable is removed, the block keeps driving the line until both registers are empty and only then releases the pin's output enable.

Top module: `uart_tx_dbuf`

## Requirements
- R1: During and after reset, txd is 1, txd_oe is 0, dre is 1 and txc is 0.
- R2: A frame is one 0 start bit, then the data bits with bit 0 first, then the parity bit if enabled, then the stop bits at 1. Each bit ends at a clock edge where baud_tick is 1.
- R3: The character length is 5 + csize bits for csize codes 0 to 4. The unused upper bits of wdata never appear on the line.
- R4: With csize code 4 (9 bits), data bit 8 is the value last written to the staging bit through wr_bit8/bit8_in. The wdata write commits it with the low byte.
- R5: par_mode 1 adds an even parity bit, par_mode 2 adds an odd parity bit, and codes 0 and 3 send no parity bit.
- R6: two_stop at 1 sends two stop bits. At 0 it sends one.
- R7: A wr_data strobe is accepted only while dre is 1. A strobe while dre is 0 is dropped, and its character never appears on the line.
- R8: The shift register loads from the holding register on the first edge where the transmitter is enabled and the line is idle, or on the very edge that ends the last stop bit of the previous frame. There is no idle cycle between back-to-back frames, and the start bit is driven in the cycle after the load.
- R9: txc goes to 1 when a frame's last stop bit ends and the holding register is empty. It goes to 0 on a txc_clr strobe or on an accepted write.
- R10: While tx_en is 1 and nothing is being sent, txd is held at 1 with txd_oe at 1. After tx_en drops, txd_oe stays 1 until both registers are empty, then goes to 0. Whenever txd_oe is 0, txd is 1.
- R11: dre goes to 0 in the cycle after an accepted write and returns to 1 when the shift register takes the character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse that ends the current bit |
| tx_en | input | 1 | Transmitter enable; clearing it takes effect once drained |
| csize | input | 3 | Character length code, length = 5 + code (0..4) |
| par_mode | input | 2 | 0/3 none, 1 even, 2 odd |
| two_stop | input | 1 | 1 selects two stop bits |
| wr_data | input | 1 | Write strobe for the low data byte |
| wdata | input | 8 | Low data byte |
| wr_bit8 | input | 1 | Write strobe for the ninth-bit staging register |
| bit8_in | input | 1 | Value for the ninth-bit staging register |
| txc_clr | input | 1 | Clears the transmit-complete flag |
| txd | output | 1 | Serial output line |
| txd_oe | output | 1 | Output enable for the pin |
| dre | output | 1 | Holding register empty |
| txc | output | 1 | Transmit complete |

## Verification
An accepted write shows up as dre low one cycle later. If the line was idle, the start bit appears one cycle after that, because the holding register and the shifter each add one register stage. After the last stop bit of a back-to-back pair, the next start bit follows in exactly the next cycle. txc changes on the edge that ends the final stop bit. The bench samples every output on the falling clock edge, so it reads the value registered at the preceding rising edge. Its monitor captures each bit in the half cycle before the tick edge that ends that bit. A scoreboard queue holds the expected frames in write order, so frames that are dropped, extra or reordered show up as mismatches.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int MIN_BITS = 5;
  localparam int MAX_BITS = 9;
  localparam int SIZE_CODES = MAX_BITS - MIN_BITS + 1;
  localparam int FRAME_W = MAX_BITS + 4;
  localparam int CNT_W = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    PAR_OFF  = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_RSV  = 2'd3
  } par_e;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [CNT_W-1:0]   len;
  } frame_t;

  function automatic int char_bits(input logic [2:0] code);
    int c;
    c = int'(code);
    if (c > SIZE_CODES - 1) c = SIZE_CODES - 1;
    return MIN_BITS + c;
  endfunction
endpackage

// File: rtl/utx_hold.sv
module utx_hold
  import utx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          csize,
  input  logic                wr_data,
  input  logic [7:0]          wdata,
  input  logic                wr_bit8,
  input  logic                bit8_in,
  input  logic                take,
  output logic                accept,
  output logic                valid,
  output logic [MAX_BITS-1:0] data
);
  logic                valid_q, valid_n;
  logic [MAX_BITS-1:0] data_q, data_n;
  logic                b8_q, b8_n;
  logic [MAX_BITS-1:0] raw;
  int                  nb;

  assign accept = wr_data && !valid_q;
  assign raw    = {b8_q, wdata};

  always_comb begin
    nb     = char_bits(csize);
    data_n = data_q;
    if (accept) begin
      for (int i = 0; i < MAX_BITS; i++) data_n[i] = (i < nb) ? raw[i] : 1'b0;
    end
    valid_n = valid_q;
    if (take)   valid_n = 1'b0;
    if (accept) valid_n = 1'b1;
    b8_n = wr_bit8 ? bit8_in : b8_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      b8_q    <= 1'b0;
    end else begin
      valid_q <= valid_n;
      if (accept)  data_q <= data_n;
      if (wr_bit8) b8_q   <= b8_n;
    end
  end

  assign valid = valid_q;
  assign data  = data_q;
endmodule

// File: rtl/utx_framer.sv
module utx_framer
  import utx_pkg::*;
(
  input  logic [MAX_BITS-1:0] data,
  input  logic [2:0]          csize,
  input  logic [1:0]          par_mode,
  input  logic                two_stop,
  output frame_t              frame
);
  logic [FRAME_W-1:0] dpad;
  logic               par_on, pbit;
  int                 nb, total;

  assign dpad = FRAME_W'(data);

  always_comb begin
    nb     = char_bits(csize);
    par_on = (par_e'(par_mode) == PAR_EVEN) || (par_e'(par_mode) == PAR_ODD);
    pbit   = (par_e'(par_mode) == PAR_ODD) ? ~(^data) : (^data);
    frame.bits    = '1;
    frame.bits[0] = 1'b0;
    for (int j = 1; j < FRAME_W; j++) begin
      if (j <= nb)                    frame.bits[j] = dpad[j-1];
      else if (j == nb + 1 && par_on) frame.bits[j] = pbit;
    end
    total     = 1 + nb + (par_on ? 1 : 0) + (two_stop ? 2 : 1);
    frame.len = CNT_W'(total);
  end
endmodule

// File: rtl/utx_shift.sv
module utx_shift
  import utx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   baud_tick,
  input  logic   load,
  input  frame_t frame_in,
  output logic   busy,
  output logic   ready,
  output logic   finish,
  output logic   line
);
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n, len_q, len_n;
  logic               busy_q, busy_n;
  logic               step;

  assign step   = busy_q && baud_tick;
  assign finish = step && (cnt_q == len_q - CNT_W'(1));
  assign ready  = !busy_q || finish;

  always_comb begin
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    len_n  = len_q;
    busy_n = busy_q;
    if (load) begin
      sh_n   = frame_in.bits;
      len_n  = frame_in.len;
      cnt_n  = '0;
      busy_n = 1'b1;
    end else if (finish) begin
      busy_n = 1'b0;
    end else if (step) begin
      sh_n  = {1'b1, sh_q[FRAME_W-1:1]};
      cnt_n = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      len_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (load || step) begin
        sh_q  <= sh_n;
        cnt_q <= cnt_n;
        len_q <= len_n;
      end
      busy_q <= busy_n;
    end
  end

  assign busy = busy_q;
  assign line = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import utx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       tx_en,
  input  logic [2:0] csize,
  input  logic [1:0] par_mode,
  input  logic       two_stop,
  input  logic       wr_data,
  input  logic [7:0] wdata,
  input  logic       wr_bit8,
  input  logic       bit8_in,
  input  logic       txc_clr,
  output logic       txd,
  output logic       txd_oe,
  output logic       dre,
  output logic       txc
);
  logic                accept, hvalid, load;
  logic [MAX_BITS-1:0] hdata;
  frame_t              frame;
  logic                busy, ready, finish, line;
  logic                active_q, active_n;
  logic                txc_q, txc_n;

  utx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .csize(csize), .wr_data(wr_data), .wdata(wdata),
    .wr_bit8(wr_bit8), .bit8_in(bit8_in), .take(load), .accept(accept),
    .valid(hvalid), .data(hdata)
  );

  utx_framer u_framer (
    .data(hdata), .csize(csize), .par_mode(par_mode), .two_stop(two_stop),
    .frame(frame)
  );

  utx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .load(load),
    .frame_in(frame), .busy(busy), .ready(ready), .finish(finish), .line(line)
  );

  assign load = active_q && hvalid && ready;

  always_comb begin
    active_n = tx_en || (active_q && (hvalid || busy));
    txc_n    = txc_q;
    if (txc_clr || accept)      txc_n = 1'b0;
    if (finish && !hvalid && !accept) txc_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      txc_q    <= 1'b0;
    end else begin
      active_q <= active_n;
      txc_q    <= txc_n;
    end
  end

  assign txd    = active_q ? line : 1'b1;
  assign txd_oe = active_q;
  assign dre    = !hvalid;
  assign txc    = txc_q;
endmodule

// File: rtl/utx_checker.sv
module utx_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic wr_data,
  input logic baud_tick,
  input logic txd,
  input logic txd_oe,
  input logic dre,
  input logic txc
);
  assert_released_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !txd_oe |-> txd);

  assert_release_after_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd_oe) |-> !$past(tx_en));

  assert_dre_drop_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dre) |-> $past(wr_data));

  assert_load_starts_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dre) |-> !txd);

  assert_txc_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txc) |-> $past(baud_tick));

  assert_txc_needs_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    txc |-> dre);
endmodule

bind uart_tx_dbuf utx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_data(wr_data),
  .baud_tick(baud_tick), .txd(txd), .txd_oe(txd_oe), .dre(dre), .txc(txc)
);

// File: tb/uart_tx_dbuf_test.sv
module uart_tx_dbuf_test;
  logic       clk, rst_n, baud_tick, tx_en, two_stop;
  logic [2:0] csize;
  logic [1:0] par_mode;
  logic       wr_data, wr_bit8, bit8_in, txc_clr;
  logic [7:0] wdata;
  logic       txd, txd_oe, dre, txc;

  int checks = 0, errors = 0, cyc = 0, tick_cnt = 0;
  logic [12:0] exp_bits[$];
  int          exp_len[$];
  string       exp_tag[$];
  logic        b8_model = 1'b0;

  bit          in_frame = 0, unexp = 0;
  int          nbit = 0, cur_len = 0, start_cyc = 0, end_cyc = 0, last_gap = 0, frames_seen = 0;
  logic [12:0] cur;

  uart_tx_dbuf uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en), .csize(csize),
    .par_mode(par_mode), .two_stop(two_stop), .wr_data(wr_data), .wdata(wdata),
    .wr_bit8(wr_bit8), .bit8_in(bit8_in), .txc_clr(txc_clr), .txd(txd),
    .txd_oe(txd_oe), .dre(dre), .txc(txc)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tick_cnt <= (tick_cnt == 3) ? 0 : tick_cnt + 1;
    baud_tick <= rst_n && (tick_cnt == 3);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: bits captured on the half cycle before the ending tick edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!in_frame && txd == 1'b0) begin
        in_frame  = 1;
        nbit      = 0;
        cur       = '1;
        last_gap  = cyc - end_cyc;
        start_cyc = cyc;
        if (exp_len.size() == 0) begin
          unexp   = 1;
          cur_len = 10;
          check(0, "R7 unexpected frame", 1, 0);
        end else begin
          unexp   = 0;
          cur_len = exp_len[0];
        end
      end
      if (in_frame && baud_tick) begin
        cur[nbit] = txd;
        nbit++;
        if (nbit == cur_len) begin
          in_frame = 0;
          end_cyc  = cyc;
          frames_seen++;
          if (!unexp) begin
            logic [12:0] mask;
            mask = 13'((1 << cur_len) - 1);
            check((cur & mask) == (exp_bits[0] & mask), exp_tag[0],
                  int'(cur & mask), int'(exp_bits[0] & mask));
            void'(exp_bits.pop_front());
            void'(exp_len.pop_front());
            void'(exp_tag.pop_front());
          end
        end
      end
    end
  end

  task automatic push_exp(input logic [7:0] d, input string tag);
    logic [12:0] b;
    logic        p;
    int          nb, idx;
    logic [8:0]  d9;
    d9 = {b8_model, d};
    nb = 5 + int'(csize);
    b = '1; b[0] = 1'b0; p = 1'b0;
    for (int i = 0; i < nb; i++) begin b[1+i] = d9[i]; p ^= d9[i]; end
    idx = 1 + nb;
    if (par_mode == 2'd1) begin b[idx] = p; idx++; end
    else if (par_mode == 2'd2) begin b[idx] = ~p; idx++; end
    exp_bits.push_back(b);
    exp_len.push_back(idx + (two_stop ? 2 : 1));
    exp_tag.push_back(tag);
  endtask

  task automatic put_char(input logic [7:0] d, input bit ok, input string tag);
    @(negedge clk);
    wdata = d; wr_data = 1'b1;
    if (ok) push_exp(d, tag);
    @(negedge clk);
    wr_data = 1'b0;
  endtask

  task automatic stage_b8(input logic v);
    @(negedge clk);
    wr_bit8 = 1'b1; bit8_in = v; b8_model = v;
    @(negedge clk);
    wr_bit8 = 1'b0;
  endtask

  task automatic drain();
    while (exp_len.size() != 0 || in_frame) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tx_en = 0; csize = 3'd3; par_mode = 2'd0; two_stop = 0;
    wr_data = 0; wdata = 0; wr_bit8 = 0; bit8_in = 0; txc_clr = 0;
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(txd_oe == 1'b0, "R1 oe", txd_oe, 0);
    check(dre == 1'b1, "R1 dre", dre, 1);
    check(txc == 1'b0, "R1 txc", txc, 0);
    rst_n = 1;
    @(negedge clk);
    tx_en = 1;
    repeat (3) @(negedge clk);
    check(txd == 1'b1 && txd_oe == 1'b1, "R10 idle high", {txd, txd_oe}, 3);

    // 8 bits, no parity, one stop
    put_char(8'hA5, 1, "R2 8N1 frame");
    check(dre == 1'b0, "R11 dre after write", dre, 0);
    @(negedge clk);
    check(txd == 1'b0, "R8 start after load", txd, 0);
    check(dre == 1'b1, "R11 dre after load", dre, 1);
    drain();

    // 5 bits from full byte, even parity
    csize = 3'd0; par_mode = 2'd1;
    put_char(8'hFF, 1, "R3 R5 5-bit even");
    drain();
    // 7 bits, odd parity, two stops
    csize = 3'd2; par_mode = 2'd2; two_stop = 1;
    put_char(8'hD3, 1, "R5 R6 7-bit odd 2 stop");
    drain();
    // parity code 3 sends none
    csize = 3'd3; par_mode = 2'd3; two_stop = 0;
    put_char(8'h3C, 1, "R5 code3 no parity");
    drain();

    // 9-bit characters with staged ninth bit
    csize = 3'd4; par_mode = 2'd2;
    stage_b8(1'b1);
    put_char(8'h3C, 1, "R4 9-bit bit8=1");
    drain();
    stage_b8(1'b0);
    put_char(8'hC3, 1, "R4 9-bit bit8=0");
    drain();

    // back-to-back and dropped write
    csize = 3'd3; par_mode = 2'd0;
    begin
      int f0;
      f0 = frames_seen;
      put_char(8'h11, 1, "R8 first frame");
      while (!dre) @(negedge clk);
      put_char(8'h22, 1, "R8 second frame");
      check(dre == 1'b0, "R7 buffer full", dre, 0);
      put_char(8'h99, 0, "R7 dropped");
      check(txc == 1'b0, "R9 txc low while pending", txc, 0);
      drain();
      check(last_gap == 1, "R8 no idle gap", last_gap, 1);
      check(frames_seen - f0 == 2, "R7 frame count", frames_seen - f0, 2);
    end

    // transmit complete
    check(txc == 1'b1, "R9 txc set", txc, 1);
    @(negedge clk); txc_clr = 1; @(negedge clk); txc_clr = 0;
    check(txc == 1'b0, "R9 txc cleared by strobe", txc, 0);
    drain();
    check(txc == 1'b0, "R9 txc stays clear", txc, 0);
    put_char(8'h5A, 1, "R9 frame");
    drain();
    check(txc == 1'b1, "R9 txc set again", txc, 1);
    put_char(8'h6B, 1, "R9 write frame");
    check(txc == 1'b0, "R9 txc cleared by write", txc, 0);
    drain();

    // deferred disable
    put_char(8'h81, 1, "R10 frame during disable");
    tx_en = 0;
    repeat (10) @(negedge clk);
    check(txd_oe == 1'b1, "R10 oe held while pending", txd_oe, 1);
    drain();
    check(txd_oe == 1'b0, "R10 oe released", txd_oe, 0);
    check(txd == 1'b1, "R10 line high released", txd, 1);

    check(exp_len.size() == 0, "R2 scoreboard empty", exp_len.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule